// File: doc/BRIEF.md
# Idle and Standby Handshake Controller

This block manages the low-power handshakes of one peripheral. The peripheral has two bus faces. The target face answers register and data transfers, and the idle-mode field governs it. The initiator face issues transfers of its own, and the standby-mode field governs it. The system raises an idle request. The peripheral reports whether it is busy, meaning that interrupt or DMA work is still pending, and whether it needs its initiator port. From these inputs the controller drives an idle acknowledge and a standby status. It also gates each face's transfer requests, so that no transfer passes while that face is idle or in standby.

Each face has three behaviours. In the forced behaviour it follows the system unconditionally. In the never behaviour it stays active for good. In the smart behaviour it waits on the peripheral's own conditions. Both fields sit in a single configuration word that software reads and writes. The fourth code of each field is reserved, and the block treats it as the never behaviour, so a bad write leaves the peripheral active.

Top module: `pwr_handshake_ctl`

## Requirements
- R1: While reset is applied and just after it ends, the configuration word reads 0, `idle_ack` is 0 and `init_standby` is 1, because both fields start in their forced codes.
- R2: The configuration word lives at byte offset 0x54. The standby field sits in bits 5:4 and the idle field in bits 3:2. A write with `reg_we`=1 to that offset is stored at the clock edge, and the new codes govern the handshakes computed from the next edge onward.
- R3: Bits 31:6 of the word always read 0. Bits 1:0 store and read back what was written and have no effect on the handshakes. A read at any other offset returns 0, and a write to any other offset changes nothing that can be read back.
- R4: With idle code 0 (forced), `idle_ack` equals the value `sys_idle_req` held one clock earlier, whatever the value of `mod_busy`.
- R5: With idle code 1 (never), `idle_ack` is 0 one clock later.
- R6: With idle code 2 (smart), a 0 on `idle_ack` rises only after a clock in which `sys_idle_req`=1 and `mod_busy`=0. Once set, it holds while the request stays high, even if the peripheral becomes busy again, and it falls one clock after the request drops.
- R7: With standby code 0 (forced), `init_standby` is 1 one clock later. With standby code 1 (never), it is 0 one clock later.
- R8: With standby code 2 (smart), `init_standby` one clock later equals the inverse of `mod_init_need`.
- R9: Code 3 in either field acts exactly as code 1 (never) does.
- R10: `tgt_xfer_en` equals `tgt_xfer_req` AND NOT `idle_ack`, and `init_xfer_en` equals `init_xfer_req` AND NOT `init_standby`. Both are combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the configuration port |
| reg_addr | input | ADDR_W (8) | Byte offset of the access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| sys_idle_req | input | 1 | System request that the target face go idle |
| mod_busy | input | 1 | Peripheral has pending interrupt or DMA work |
| mod_init_need | input | 1 | Peripheral needs its initiator port |
| idle_ack | output | 1 | Target face is idle and acknowledges the request |
| init_standby | output | 1 | Initiator face is in standby |
| tgt_xfer_req | input | 1 | Incoming transfer on the target face |
| tgt_xfer_en | output | 1 | Target transfer allowed through |
| init_xfer_req | input | 1 | Outgoing transfer from the initiator face |
| init_xfer_en | output | 1 | Initiator transfer allowed through |

## Verification
The hardest case to reach is the smart-idle hold. The acknowledge must already be set, the request must stay high, and the peripheral must then turn busy again without the acknowledge dropping. The bench therefore changes the idle request only rarely, so that it stays high for long stretches, and flips `mod_busy` at about half of all clocks. Software writes land at random moments, so mode changes also fall in the middle of an acknowledged request, and the reserved code is written to both fields.

// File: rtl/pwr_hs_pkg.sv
package pwr_hs_pkg;

   localparam int unsigned FIELD_W    = 2;
   localparam int unsigned RSVD_LSB   = 0;
   localparam int unsigned IDLE_LSB   = 2;
   localparam int unsigned STBY_LSB   = 4;
   localparam int unsigned CFG_USED_W = 6;

   typedef enum logic [1:0] {
      IDL_FORCE = 2'd0,
      IDL_NEVER = 2'd1,
      IDL_SMART = 2'd2
   } idle_mode_e;

   typedef enum logic [1:0] {
      STB_FORCE = 2'd0,
      STB_NEVER = 2'd1,
      STB_SMART = 2'd2
   } stby_mode_e;

   typedef enum logic {
      TGT_ACTIVE = 1'b0,
      TGT_IDLE   = 1'b1
   } tgt_state_e;

   // The reserved code fails safe into the never-idle behaviour
   function automatic idle_mode_e decode_idle(input logic [FIELD_W-1:0] code);
      idle_mode_e m;
      case (code)
         2'd0:    m = IDL_FORCE;
         2'd2:    m = IDL_SMART;
         default: m = IDL_NEVER;
      endcase
      return m;
   endfunction

   function automatic stby_mode_e decode_stby(input logic [FIELD_W-1:0] code);
      stby_mode_e m;
      case (code)
         2'd0:    m = STB_FORCE;
         2'd2:    m = STB_SMART;
         default: m = STB_NEVER;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/pwr_hs_cfg_reg.sv
module pwr_hs_cfg_reg
   import pwr_hs_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned CFG_OFFSET = 'h54
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output idle_mode_e        idle_mode,
   output stby_mode_e        stby_mode
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CFG_OFFSET);
   localparam int unsigned       PAD_W    = DATA_W - CFG_USED_W;

   generate
      if (DATA_W < CFG_USED_W) begin : g_bad_width
         $error("pwr_hs_cfg_reg: DATA_W must hold all configuration fields");
      end
      if (CFG_OFFSET >= (1 << ADDR_W)) begin : g_bad_offset
         $error("pwr_hs_cfg_reg: CFG_OFFSET does not fit in ADDR_W");
      end
      if ((CFG_OFFSET % 4) != 0) begin : g_bad_align
         $error("pwr_hs_cfg_reg: CFG_OFFSET must be word aligned");
      end
   endgenerate

   logic [CFG_USED_W-1:0] cfg_q;
   logic                  hit;

   assign hit = (addr == HIT_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en && hit) begin
         cfg_q <= wdata[CFG_USED_W-1:0];
      end
   end

   assign idle_mode = decode_idle(cfg_q[IDLE_LSB +: FIELD_W]);
   assign stby_mode = decode_stby(cfg_q[STBY_LSB +: FIELD_W]);

   generate
      if (PAD_W > 0) begin : g_pad
         assign rdata = hit ? {{PAD_W{1'b0}}, cfg_q} : '0;
      end else begin : g_nopad
         assign rdata = hit ? cfg_q : '0;
      end
   endgenerate

   AST_WRITE_IDLE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit) |=> (idle_mode == decode_idle($past(wdata[IDLE_LSB +: FIELD_W])))) // R2
      else $error("idle field write not applied");
   AST_WRITE_STBY_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit) |=> (stby_mode == decode_stby($past(wdata[STBY_LSB +: FIELD_W])))) // R2
      else $error("standby field write not applied");
   AST_MISS_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && hit) |=> ($stable(idle_mode) && $stable(stby_mode))) // R3
      else $error("mode changed without a write to the word");

endmodule

// File: rtl/pwr_hs_target_fsm.sv
module pwr_hs_target_fsm
   import pwr_hs_pkg::*;
#(
   parameter int unsigned REQ_SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  idle_mode_e mode,
   input  logic       sys_req,
   input  logic       busy,
   output logic       ack
);

   generate
      if (REQ_SYNC_STAGES > 4) begin : g_bad_sync
         $error("pwr_hs_target_fsm: REQ_SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic req_eff;

   generate
      if (REQ_SYNC_STAGES == 0) begin : g_direct
         assign req_eff = sys_req;
      end else begin : g_sync
         logic [REQ_SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q <= {sync_q[REQ_SYNC_STAGES-1:0], sys_req} >> 0;
            end
         end
         assign req_eff = sync_q[REQ_SYNC_STAGES-1];
      end
   endgenerate

   tgt_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (mode)
         IDL_FORCE: state_d = req_eff ? TGT_IDLE : TGT_ACTIVE;
         IDL_SMART: begin
            if (!req_eff) begin
               state_d = TGT_ACTIVE;
            end else if (state_q == TGT_ACTIVE && !busy) begin
               state_d = TGT_IDLE;
            end
         end
         default:   state_d = TGT_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TGT_ACTIVE;
      end else begin
         state_q <= state_d;
      end
   end

   assign ack = (state_q == TGT_IDLE);

   AST_NEVER_STAYS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == IDL_NEVER) |=> !ack) // R5
      else $error("never-idle mode acknowledged");
   AST_FORCE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == IDL_FORCE && req_eff) |=> ack) // R4
      else $error("forced idle did not acknowledge");
   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_eff |=> !ack) // R6
      else $error("acknowledge held without a request");
   AST_SMART_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == IDL_SMART && !ack && busy) |=> !ack) // R6
      else $error("smart idle acknowledged while busy");
   AST_SMART_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == IDL_SMART && ack && req_eff) |=> ack) // R6
      else $error("smart idle dropped under a held request");

endmodule

// File: rtl/pwr_hs_initiator_fsm.sv
module pwr_hs_initiator_fsm
   import pwr_hs_pkg::*;
#(
   parameter bit STBY_RESET_VAL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  stby_mode_e mode,
   input  logic       need,
   output logic       standby
);

   logic stby_q, stby_d;

   always_comb begin
      unique case (mode)
         STB_FORCE: stby_d = 1'b1;
         STB_SMART: stby_d = !need;
         default:   stby_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stby_q <= STBY_RESET_VAL;
      end else begin
         stby_q <= stby_d;
      end
   end

   assign standby = stby_q;

   AST_FORCE_STBY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == STB_FORCE) |=> standby) // R7
      else $error("forced standby not entered");
   AST_NEVER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == STB_NEVER) |=> !standby) // R7
      else $error("never-standby mode entered standby");
   AST_SMART_NEED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == STB_SMART && need) |=> !standby) // R8
      else $error("smart standby while initiator needed");
   AST_SMART_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == STB_SMART && !need) |=> standby) // R8
      else $error("smart standby not entered when free");

endmodule

// File: rtl/pwr_handshake_ctl.sv
module pwr_handshake_ctl
   import pwr_hs_pkg::*;
#(
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned ADDR_W          = 8,
   parameter int unsigned CFG_OFFSET      = 'h54,
   parameter int unsigned REQ_SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              sys_idle_req,
   input  logic              mod_busy,
   input  logic              mod_init_need,
   output logic              idle_ack,
   output logic              init_standby,
   input  logic              tgt_xfer_req,
   output logic              tgt_xfer_en,
   input  logic              init_xfer_req,
   output logic              init_xfer_en
);

   idle_mode_e idle_mode;
   stby_mode_e stby_mode;

   pwr_hs_cfg_reg #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .CFG_OFFSET (CFG_OFFSET)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .idle_mode (idle_mode),
      .stby_mode (stby_mode)
   );

   pwr_hs_target_fsm #(
      .REQ_SYNC_STAGES (REQ_SYNC_STAGES)
   ) u_tgt (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (idle_mode),
      .sys_req (sys_idle_req),
      .busy    (mod_busy),
      .ack     (idle_ack)
   );

   pwr_hs_initiator_fsm #(
      .STBY_RESET_VAL (1'b1)
   ) u_init (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (stby_mode),
      .need    (mod_init_need),
      .standby (init_standby)
   );

   assign tgt_xfer_en  = tgt_xfer_req  && !idle_ack;
   assign init_xfer_en = init_xfer_req && !init_standby;

   AST_TGT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_xfer_req && !idle_ack) |-> tgt_xfer_en) // R10
      else $error("target transfer blocked while active");
   AST_TGT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      idle_ack |-> !tgt_xfer_en) // R10
      else $error("target transfer passed while idle");
   AST_INIT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      init_standby |-> !init_xfer_en) // R10
      else $error("initiator transfer passed in standby");

endmodule

// File: tb/sim_pwr_handshake_ctl.sv
`timescale 1ns/1ps
module sim_pwr_handshake_ctl;

   localparam int DW = 32;
   localparam int AW = 8;
   localparam logic [AW-1:0] CFG_ADDR = 8'h54;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          sys_idle_req = 1'b0;
   logic          mod_busy = 1'b0;
   logic          mod_init_need = 1'b0;
   logic          idle_ack;
   logic          init_standby;
   logic          tgt_xfer_req = 1'b0;
   logic          tgt_xfer_en;
   logic          init_xfer_req = 1'b0;
   logic          init_xfer_en;

   always #5 clk = ~clk;

   pwr_handshake_ctl u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_we        (reg_we),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .sys_idle_req  (sys_idle_req),
      .mod_busy      (mod_busy),
      .mod_init_need (mod_init_need),
      .idle_ack      (idle_ack),
      .init_standby  (init_standby),
      .tgt_xfer_req  (tgt_xfer_req),
      .tgt_xfer_en   (tgt_xfer_en),
      .init_xfer_req (init_xfer_req),
      .init_xfer_en  (init_xfer_en)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference state
   logic [5:0] m_cfg  = 6'd0;
   logic       m_ack  = 1'b0;
   logic       m_stby = 1'b1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic string idle_tag(input logic [1:0] c);
      case (c)
         2'd0: return "R4";
         2'd1: return "R5";
         2'd2: return "R6";
         default: return "R9";
      endcase
   endfunction

   function automatic string stby_tag(input logic [1:0] c);
      case (c)
         2'd2: return "R8";
         2'd3: return "R9";
         default: return "R7";
      endcase
   endfunction

   // model advance at a clock edge, from the inputs held across it
   task automatic model_step();
      logic [1:0] ic;
      logic [1:0] sc;
      ic = m_cfg[3:2];
      sc = m_cfg[5:4];
      case (ic)
         2'd0: m_ack = sys_idle_req;
         2'd2: m_ack = m_ack ? sys_idle_req : (sys_idle_req && !mod_busy);
         default: m_ack = 1'b0;
      endcase
      case (sc)
         2'd0: m_stby = 1'b1;
         2'd2: m_stby = !mod_init_need;
         default: m_stby = 1'b0;
      endcase
      if (reg_we && reg_addr == CFG_ADDR) m_cfg = reg_wdata[5:0];
   endtask

   task automatic compare_all();
      logic [DW-1:0] exp_rd;
      exp_rd = (reg_addr == CFG_ADDR) ? {26'd0, m_cfg} : '0;
      chk(idle_ack == m_ack, idle_tag(m_cfg[3:2]), "idle_ack", idle_ack, m_ack);
      chk(init_standby == m_stby, stby_tag(m_cfg[5:4]), "init_standby", init_standby, m_stby);
      chk(reg_rdata == exp_rd, (reg_addr == CFG_ADDR) ? "R2" : "R3", "reg_rdata", reg_rdata, exp_rd);
      chk(tgt_xfer_en == (tgt_xfer_req && !m_ack), "R10", "tgt_xfer_en",
          tgt_xfer_en, tgt_xfer_req && !m_ack);
      chk(init_xfer_en == (init_xfer_req && !m_stby), "R10", "init_xfer_en",
          init_xfer_en, init_xfer_req && !m_stby);
   endtask

   // one clock: inputs already set, cross the edge, compare at the falling edge
   task automatic cycle();
      @(posedge clk);
      model_step();
      @(negedge clk);
      #1;
      compare_all();
   endtask

   task automatic write_cfg(input logic [AW-1:0] a, input logic [DW-1:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      cycle();
      reg_we = 1'b0; reg_addr = CFG_ADDR;
   endtask

   initial begin
      // R1: reset values
      repeat (3) @(negedge clk);
      reg_addr = CFG_ADDR;
      #1;
      chk(reg_rdata == '0, "R1", "reset rdata", reg_rdata, 0);
      chk(idle_ack == 1'b0, "R1", "reset idle_ack", idle_ack, 0);
      chk(init_standby == 1'b1, "R1", "reset init_standby", init_standby, 1);
      rst_n = 1'b1;
      sys_idle_req = 1'b1;
      cycle();
      chk(idle_ack == 1'b1, "R4", "forced idle after reset", idle_ack, 1);
      chk(init_standby == 1'b1, "R1", "standby after reset", init_standby, 1);
      sys_idle_req = 1'b0;
      cycle();

      // R3: upper bits read zero, low reserved bits read back
      write_cfg(CFG_ADDR, 32'hFFFF_FFC3);
      #1;
      chk(reg_rdata == 32'h0000_0003, "R3", "upper bits zero", reg_rdata, 32'h3);
      // R3: write elsewhere ignored
      write_cfg(8'h50, 32'h0000_0028);
      #1;
      chk(reg_rdata == 32'h0000_0003, "R3", "foreign write ignored", reg_rdata, 32'h3);
      reg_addr = 8'h50;
      #1;
      chk(reg_rdata == '0, "R3", "foreign read zero", reg_rdata, 0);
      reg_addr = CFG_ADDR;

      // R9: code 3 in both fields keeps everything active
      write_cfg(CFG_ADDR, 32'h0000_003C);
      sys_idle_req = 1'b1; mod_busy = 1'b0; mod_init_need = 1'b0;
      repeat (4) cycle();
      chk(idle_ack == 1'b0, "R9", "reserved idle code", idle_ack, 0);
      chk(init_standby == 1'b0, "R9", "reserved standby code", init_standby, 0);

      // R6: smart idle waits for busy to clear, then holds through busy
      sys_idle_req = 1'b0;
      write_cfg(CFG_ADDR, 32'h0000_0028);
      sys_idle_req = 1'b1; mod_busy = 1'b1;
      repeat (3) cycle();
      chk(idle_ack == 1'b0, "R6", "smart idle while busy", idle_ack, 0);
      mod_busy = 1'b0;
      cycle();
      chk(idle_ack == 1'b1, "R6", "smart idle after busy clears", idle_ack, 1);
      mod_busy = 1'b1;
      repeat (2) cycle();
      chk(idle_ack == 1'b1, "R6", "smart idle hold through busy", idle_ack, 1);
      sys_idle_req = 1'b0;
      cycle();
      chk(idle_ack == 1'b0, "R6", "smart idle release", idle_ack, 0);
      // R8: smart standby tracks need
      mod_init_need = 1'b1;
      cycle();
      chk(init_standby == 1'b0, "R8", "smart standby with need", init_standby, 0);
      mod_init_need = 1'b0;
      cycle();
      chk(init_standby == 1'b1, "R8", "smart standby without need", init_standby, 1);

      // random phase: long request runs, busy toggling, random writes
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 15) == 0) sys_idle_req = ~sys_idle_req;
         mod_busy      = $urandom_range(0, 1);
         mod_init_need = ($urandom_range(0, 3) != 0) ? mod_init_need : ~mod_init_need;
         tgt_xfer_req  = $urandom_range(0, 1);
         init_xfer_req = $urandom_range(0, 1);
         reg_we        = ($urandom_range(0, 39) == 0);
         reg_addr      = ($urandom_range(0, 7) == 0) ? 8'h58 : CFG_ADDR;
         reg_wdata     = $urandom;
         cycle();
      end
      reg_we = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule